// File: doc/BRIEF.md
# EDO DRAM Access and Refresh Controller

This block connects a synchronous host request port to an asynchronous x4 extended-data-out DRAM whose address pins are shared between row and column. The host gives a 22-bit word address, a direction bit and four bits of write data through a valid/ready handshake. The controller then opens a row with the active-low row strobe and selects a column with the active-low column strobe. For a read it returns the captured nibble with a one-cycle valid pulse. Every strobe width is a whole number of system clocks set by a parameter.

Writes are always issued as early writes. The write enable falls together with the row strobe, well before the column strobe falls, and output enable stays high. The memory's outputs therefore never drive the bus while the controller does. A free-running timer raises a refresh request at a fixed interval. The request is served at the next idle point as a column-before-row refresh cycle, ahead of any waiting host request and without cutting into an access already under way.

One build-time parameter picks the address split. The narrow-row variant uses 11 row and 11 column bits and 2048 refresh rows. The wide-row variant uses 12 row and 10 column bits and 4096 refresh rows.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, the row, column, write-enable and output-enable strobes are all high, `reqReady` is high, `rdValid` is low and `dramDqOe` is low.
- R2: With `FOUR_K`=0, address bits 21..11 appear on pins 10..0 when the row strobe falls, and bits 10..0 appear on pins 10..0 when the column strobe falls. Pin 11 is low at both points.
- R3: With `FOUR_K`=1, address bits 21..10 appear on pins 11..0 when the row strobe falls, and bits 9..0 appear on pins 9..0 when the column strobe falls. Pins 11 and 10 are low at the column point.
- R4: A read keeps write enable high and drives output enable low while the column strobe is low. The nibble on `dramDqIn` in the last column-low cycle is presented on `rdData` with `rdValid` high for exactly one cycle, in the cycle right after the column strobe rises.
- R5: A write drives write enable low and `dramDqOe` high from the fall of the row strobe, so write enable is already low before the column strobe falls. Output enable stays high throughout, and `dramDqOe` is never high while output enable is low.
- R6: In an access the row strobe is low alone for `T_RCD` cycles before the column strobe falls. The column strobe stays low for `T_CAS` cycles. Both strobes are then high for at least `T_RP` cycles before either falls again.
- R7: A refresh lowers the column strobe first, with write enable high. The row strobe follows `T_CSR` cycles later and stays low for `T_RASR` cycles. The refresh cycle ends with the same precharge as an access.
- R8: A refresh request is raised every `REF_INTERVAL` cycles after reset. A pending request is served before any host request, so refresh cycles still occur while the host keeps `reqValid` high without pause.
- R9: A refresh request that arises during an access waits until that access and its precharge have finished. Access strobe widths are unchanged under continuous traffic.
- R10: Each `reqValid`&&`reqReady` handshake produces exactly one DRAM access at the handshake address and direction. `reqReady` is low whenever either the row strobe or the column strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address (row bits high, column bits low) |
| reqWdata | input | 4 | Write nibble |
| rdValid | output | 1 | One-cycle pulse marking returned read data |
| rdData | output | 4 | Read nibble |
| dramAddr | output | 12 | Multiplexed row/column address pins |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | 4 | Data driven toward the DRAM |
| dramDqOe | output | 1 | Enables the controller's data drivers |
| dramDqIn | input | 4 | Data returned by the DRAM |

## Verification
The hardest situation to reach is a refresh request that matures while an access is running and must then win against a host request that is already waiting. The stimulus keeps `reqValid` asserted back to back for well over several refresh intervals, with the interval shortened for the bench. This makes the timer expire inside accesses. A bus model of the memory measures every strobe width and the column-before-row lead. Refresh cycles must still appear, and no access may be shortened. Two instances, one per address split, run the same traffic, and each access's decoded address is compared with the handshake that caused it.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW,
    S_COL,
    S_PRE,
    S_REFC,
    S_REFR
  } stateT;

  // Strobes from the control FSM to the datapath and the pins
  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic oeN;
    logic driveDq;
    logic selRow;
    logic selCol;
    logic latchReq;
    logic capture;
  } strobeT;

endpackage

// File: rtl/edo_ctrl_fsm.sv
module edo_ctrl_fsm
  import edo_pkg::*;
#(
  parameter int T_RCD        = 9,
  parameter int T_CAS        = 4,
  parameter int T_RP         = 8,
  parameter int T_CSR        = 2,
  parameter int T_RASR       = 12,
  parameter int REF_INTERVAL = 3900
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output strobeT stb
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_T = maxOf(maxOf(maxOf(T_RCD, T_CAS), maxOf(T_RP, T_CSR)), T_RASR);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic [REF_W-1:0] refTimer;
  logic             refPending;
  logic             refTick;
  logic             cntDone;

  assign refTick  = (refTimer == REF_W'(REF_INTERVAL - 1));
  assign cntDone  = (cnt == '0);
  assign reqReady = (state == S_IDLE) && !refPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      isWrite    <= 1'b0;
      refTimer   <= '0;
      refPending <= 1'b0;
    end else begin
      refTimer <= refTick ? '0 : refTimer + 1'b1;
      if (state == S_IDLE && refPending) refPending <= 1'b0;
      if (refTick) refPending <= 1'b1;

      case (state)
        S_IDLE: begin
          if (refPending) begin
            state <= S_REFC;
            cnt   <= CNT_W'(T_CSR - 1);
          end else if (reqValid) begin
            state   <= S_ROW;
            cnt     <= CNT_W'(T_RCD - 1);
            isWrite <= reqWrite;
          end
        end
        S_ROW: begin
          if (cntDone) begin
            state <= S_COL;
            cnt   <= CNT_W'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_COL, S_REFR: begin
          if (cntDone) begin
            state <= S_PRE;
            cnt   <= CNT_W'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_REFC: begin
          if (cntDone) begin
            state <= S_REFR;
            cnt   <= CNT_W'(T_RASR - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (cntDone) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.rasN     = 1'b1;
    stb.casN     = 1'b1;
    stb.weN      = 1'b1;
    stb.oeN      = 1'b1;
    stb.latchReq = (state == S_IDLE) && !refPending && reqValid;
    case (state)
      S_ROW: begin
        stb.rasN    = 1'b0;
        stb.weN     = !isWrite;
        stb.driveDq = isWrite;
        stb.selRow  = 1'b1;
      end
      S_COL: begin
        stb.rasN    = 1'b0;
        stb.casN    = 1'b0;
        stb.weN     = !isWrite;
        stb.oeN     = isWrite;
        stb.driveDq = isWrite;
        stb.selCol  = 1'b1;
        stb.capture = !isWrite && cntDone;
      end
      S_REFC: stb.casN = 1'b0;
      S_REFR: begin
        stb.casN = 1'b0;
        stb.rasN = 1'b0;
      end
      default: ;
    endcase
  end

  // R10: no new request while a strobe is active
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rasN || !stb.casN) |-> !reqReady);

  // R5: write enable already low on the cycle before the column strobe falls
  assert_early_we_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stb.casN) && !stb.rasN && !stb.weN) |-> $past(!stb.weN));

  // R7: refresh row strobe falls under an already low column strobe, write enable high
  assert_cbr_we_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stb.rasN) && $past(!stb.casN)) |-> stb.weN);

  // R6: a cycle's end is followed by a precharge cycle
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.rasN) |=> (stb.rasN && stb.casN));

endmodule

// File: rtl/edo_datapath.sv
module edo_datapath
  import edo_pkg::*;
#(
  parameter bit FOUR_K = 1'b0,
  parameter int ADDR_W = 22,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   dramDqIn,
  output logic [ADDR_W/2:0]   dramAddr,
  output logic [DATA_W-1:0]   dramDqOut,
  output logic                dramDqOe,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData
);

  localparam int PIN_W = ADDR_W / 2 + 1;
  localparam int COL_W = FOUR_K ? (ADDR_W / 2 - 1) : (ADDR_W / 2);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [ROW_W-1:0]  rowBits;
  logic [COL_W-1:0]  colBits;

  assign rowBits = addrQ[ADDR_W-1:COL_W];
  assign colBits = addrQ[COL_W-1:0];

  always_comb begin
    if (stb.selRow)      dramAddr = PIN_W'(rowBits);
    else if (stb.selCol) dramAddr = PIN_W'(colBits);
    else                 dramAddr = '0;
  end

  assign dramDqOut = wdataQ;
  assign dramDqOe  = stb.driveDq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      rdValid <= stb.capture;
      if (stb.capture) rdData <= dramDqIn;
    end
  end

  // R4: read data valid is a single-cycle pulse
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R2 R3: unused upper pins are low while the column is presented
  assert_col_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.casN && !stb.rasN) |-> (dramAddr[PIN_W-1:COL_W] == '0));

  // R5: controller drives data only with write enable low and output enable high
  assert_drive_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.driveDq |-> (!stb.weN && stb.oeN));

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter bit FOUR_K       = 1'b0,
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 9,
  parameter int T_CAS        = 4,
  parameter int T_RP         = 8,
  parameter int T_CSR        = 2,
  parameter int T_RASR       = 12,
  parameter int REF_INTERVAL = 3900
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W/2:0]   dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic                dramOeN,
  output logic [DATA_W-1:0]   dramDqOut,
  output logic                dramDqOe,
  input  logic [DATA_W-1:0]   dramDqIn
);

  strobeT stb;

  edo_ctrl_fsm #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
    .T_CSR(T_CSR), .T_RASR(T_RASR), .REF_INTERVAL(REF_INTERVAL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  edo_datapath #(
    .FOUR_K(FOUR_K), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramDqIn(dramDqIn), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .rdValid(rdValid), .rdData(rdData)
  );

  assign dramRasN = stb.rasN;
  assign dramCasN = stb.casN;
  assign dramWeN  = stb.weN;
  assign dramOeN  = stb.oeN;

endmodule

// File: tb/edo_dram_model.sv
module edo_dram_model #(
  parameter bit    FOUR_K = 1'b0,
  parameter int    T_RCD  = 9,
  parameter int    T_CAS  = 4,
  parameter int    T_RP   = 8,
  parameter int    T_CSR  = 2,
  parameter int    T_RASR = 12,
  parameter string TAG    = "x"
) (
  input  logic        clk,
  input  logic [11:0] addr,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [3:0]  dqOut,
  input  logic        dqOe,
  output logic [3:0]  dqIn,
  output logic        accEvt,
  output logic [21:0] accKey,
  output logic        accWrite,
  output int          refCount,
  output int          nChecks,
  output int          nFails
);

  localparam int COL_W = FOUR_K ? 10 : 11;
  localparam string RSPLIT = FOUR_K ? "R3" : "R2";

  logic [3:0]  mem [int unsigned];
  logic        prevRas, prevCas, prevWe, inRef;
  logic [11:0] rowQ;
  logic [21:0] key;
  int          rasOnly, casLow, rasLow, csrCnt, highCnt;

  initial begin
    dqIn = '0; accEvt = 1'b0; accKey = '0; accWrite = 1'b0;
    refCount = 0; nChecks = 0; nFails = 0;
    prevRas = 1'b1; prevCas = 1'b1; prevWe = 1'b1; inRef = 1'b0; rowQ = '0;
    rasOnly = 0; casLow = 0; rasLow = 0; csrCnt = 0; highCnt = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", TAG, req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    accEvt = 1'b0;
    if (prevRas && prevCas && (!rasN || !casN))
      chk(highCnt >= T_RP, "R6 precharge length", highCnt, T_RP);
    if (!oeN && dqOe) chk(1'b0, "R5 bus contention", 1, 0);

    if (prevRas && !rasN) begin
      if (casN) begin
        rowQ  = addr;
        inRef = 1'b0;
        if (!FOUR_K) chk(addr[11] == 1'b0, "R2 row pin 11 low", int'(addr[11]), 0);
      end else begin
        chk(csrCnt == T_CSR, "R7 column lead before row", csrCnt, T_CSR);
      end
    end

    if (prevCas && !casN) begin
      if (!rasN) begin
        chk(rasOnly == T_RCD, "R6 row-to-column delay", rasOnly, T_RCD);
        chk(addr[11:COL_W] == '0, {RSPLIT, " column upper pins low"},
            int'(addr[11:COL_W]), 0);
        key = FOUR_K ? {rowQ[11:0], addr[9:0]} : {rowQ[10:0], addr[10:0]};
        accEvt   = 1'b1;
        accKey   = key;
        accWrite = !weN;
        if (!weN) begin
          chk(!prevWe, "R5 write enable before column", int'(prevWe), 0);
          chk(oeN && dqOe, "R5 output enable high and data driven", int'({oeN, dqOe}), 3);
          mem[int'(key)] = dqOut;
        end else begin
          chk(!oeN, "R4 output enable low on read", int'(oeN), 0);
          dqIn = mem.exists(int'(key)) ? mem[int'(key)] : 4'h0;
        end
      end else begin
        refCount++;
        inRef = 1'b1;
        chk(weN, "R7 write enable high in refresh", int'(weN), 1);
      end
    end

    if (!prevCas && casN && !inRef) chk(casLow == T_CAS, "R6 column strobe width", casLow, T_CAS);
    if (!prevRas && rasN && inRef)  chk(rasLow == T_RASR, "R7 refresh row width", rasLow, T_RASR);

    rasOnly = (!rasN && casN) ? rasOnly + 1 : 0;
    casLow  = !casN ? casLow + 1 : 0;
    rasLow  = !rasN ? rasLow + 1 : 0;
    csrCnt  = (!casN && rasN) ? csrCnt + 1 : 0;
    highCnt = (rasN && casN) ? highCnt + 1 : 0;
    prevRas = rasN;
    prevCas = casN;
    prevWe  = weN;
  end

endmodule

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;

  localparam int REF_INT = 400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;

  logic        ready2, rdValid2, ras2, cas2, we2, oe2, dqOe2;
  logic        ready4, rdValid4, ras4, cas4, we4, oe4, dqOe4;
  logic [3:0]  rdData2, rdData4, dqOut2, dqOut4, dqIn2, dqIn4;
  logic [11:0] addr2, addr4;
  logic        acc2, acc4, accW2, accW4;
  logic [21:0] key2, key4;
  int          ref2, ref4, mChk2, mChk4, mFail2, mFail4;

  int checks = 0;
  int errors = 0;
  logic [22:0] expKey2[$];
  logic [22:0] expKey4[$];
  logic [3:0]  expRd[$];
  logic [3:0]  shadow [int unsigned];

  always #2 clk = ~clk;

  edo_dram_ctrl #(.FOUR_K(1'b0), .REF_INTERVAL(REF_INT)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(ready2),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid2), .rdData(rdData2), .dramAddr(addr2),
    .dramRasN(ras2), .dramCasN(cas2), .dramWeN(we2), .dramOeN(oe2),
    .dramDqOut(dqOut2), .dramDqOe(dqOe2), .dramDqIn(dqIn2));

  edo_dram_ctrl #(.FOUR_K(1'b1), .REF_INTERVAL(REF_INT)) dutWide_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(ready4),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid4), .rdData(rdData4), .dramAddr(addr4),
    .dramRasN(ras4), .dramCasN(cas4), .dramWeN(we4), .dramOeN(oe4),
    .dramDqOut(dqOut4), .dramDqOe(dqOe4), .dramDqIn(dqIn4));

  edo_dram_model #(.FOUR_K(1'b0), .TAG("2K")) mem2_i (
    .clk(clk), .addr(addr2), .rasN(ras2), .casN(cas2), .weN(we2), .oeN(oe2),
    .dqOut(dqOut2), .dqOe(dqOe2), .dqIn(dqIn2), .accEvt(acc2), .accKey(key2),
    .accWrite(accW2), .refCount(ref2), .nChecks(mChk2), .nFails(mFail2));

  edo_dram_model #(.FOUR_K(1'b1), .TAG("4K")) mem4_i (
    .clk(clk), .addr(addr4), .rasN(ras4), .casN(cas4), .weN(we4), .oeN(oe4),
    .dqOut(dqOut4), .dqOe(dqOe4), .dqIn(dqIn4), .accEvt(acc4), .accKey(key4),
    .accWrite(accW4), .refCount(ref4), .nChecks(mChk4), .nFails(mFail4));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    checks += mChk2 + mChk4;
    errors += mFail2 + mFail4;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic doReq(input bit w, input logic [21:0] a, input logic [3:0] d);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    while (!ready2) @(negedge clk);
    expKey2.push_back({w, a});
    expKey4.push_back({w, a});
    if (w) shadow[int'(a)] = d;
    else expRd.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: sample after each rising edge settles
  logic prevCasMon = 1'b1;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (acc2) begin
        if (expKey2.size() == 0) chk(1'b0, "R10 unexpected access (2K)", int'(key2), 0);
        else begin
          logic [22:0] e;
          e = expKey2.pop_front();
          chk({accW2, key2} == e, "R2 R10 access address/direction (2K)",
              int'({accW2, key2}), int'(e));
        end
      end
      if (acc4) begin
        if (expKey4.size() == 0) chk(1'b0, "R10 unexpected access (4K)", int'(key4), 0);
        else begin
          logic [22:0] e;
          e = expKey4.pop_front();
          chk({accW4, key4} == e, "R3 R10 access address/direction (4K)",
              int'({accW4, key4}), int'(e));
        end
      end
      if (rdValid2) begin
        chk(cas2 && !prevCasMon, "R4 rdValid right after column rise", int'(cas2), 1);
        chk(rdValid4 && rdData4 == rdData2, "R3 wide variant returns same data",
            int'(rdData4), int'(rdData2));
        if (expRd.size() == 0) chk(1'b0, "R4 unexpected read data", int'(rdData2), 0);
        else begin
          logic [3:0] e;
          e = expRd.pop_front();
          chk(rdData2 == e, "R4 read data", int'(rdData2), int'(e));
        end
      end
      if ((!ras2 || !cas2) && ready2) chk(1'b0, "R10 ready while strobe active", 1, 0);
    end
    prevCasMon = cas2;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  initial begin
    int refBefore;
    repeat (5) @(negedge clk);
    // R1: reset state on both variants
    chk(ras2 && cas2 && we2 && oe2, "R1 strobes high in reset", int'({ras2, cas2, we2, oe2}), 15);
    chk(ras4 && cas4 && we4 && oe4, "R1 strobes high in reset (4K)", int'({ras4, cas4, we4, oe4}), 15);
    chk(ready2 && !rdValid2 && !dqOe2, "R1 ready/rdValid/dqOe in reset",
        int'({ready2, rdValid2, dqOe2}), 4);
    rstN = 1'b1;

    // R8: first refresh after REF_INT cycles of idle
    repeat (REF_INT - 20) @(negedge clk);
    chk(ref2 == 0, "R8 no refresh before interval", ref2, 0);
    repeat (50) @(negedge clk);
    chk(ref2 == 1, "R8 one refresh after interval", ref2, 1);
    chk(ref4 == 1, "R8 one refresh after interval (4K)", ref4, 1);

    // Corner addresses and a spread of patterns: write then read back
    doReq(1'b1, 22'h000000, 4'h5);
    doReq(1'b1, 22'h3FFFFF, 4'hA);
    doReq(1'b1, 22'h200400, 4'h3);
    doReq(1'b1, 22'h0007FF, 4'hC);
    doReq(1'b0, 22'h000000, 4'h0);
    doReq(1'b0, 22'h3FFFFF, 4'h0);
    doReq(1'b0, 22'h200400, 4'h0);
    doReq(1'b0, 22'h0007FF, 4'h0);
    doReq(1'b0, 22'h155555, 4'h0);
    for (int i = 0; i < 8; i++) begin
      doReq(1'b1, 22'((i * 32'h0009_7F4B + 32'h1234) & 32'h3FFFFF), 4'(i * 7 + 1));
    end
    for (int i = 7; i >= 0; i--) begin
      doReq(1'b0, 22'((i * 32'h0009_7F4B + 32'h1234) & 32'h3FFFFF), 4'h0);
    end

    // R8 R9: saturated traffic, refresh must still be inserted between accesses
    refBefore = ref2;
    reqValid = 1'b1;
    for (int i = 0; i < 80; i++) begin
      logic [21:0] a;
      a = 22'((i * 32'h0013_3A07) & 32'h3FFFFF);
      reqValid = 1'b1; reqWrite = i[0]; reqAddr = a; reqWdata = 4'(i);
      while (!ready2) @(negedge clk);
      expKey2.push_back({i[0], a});
      expKey4.push_back({i[0], a});
      if (i[0]) shadow[int'(a)] = 4'(i);
      else expRd.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(ref2 - refBefore >= 3, "R8 R9 refresh served under continuous requests",
        ref2 - refBefore, 3);

    repeat (60) @(negedge clk);
    chk(expKey2.size() == 0, "R10 every handshake produced an access (2K)", expKey2.size(), 0);
    chk(expKey4.size() == 0, "R10 every handshake produced an access (4K)", expKey4.size(), 0);
    chk(expRd.size() == 0, "R4 every read returned data", expRd.size(), 0);
    chk(ref2 == ref4, "R8 both variants refresh alike", ref4, ref2);
    finishRun();
  end

endmodule